// File: doc/BRIEF.md
# Dispatch Slot Arbiter with Flat-Access Pairing

This block sits between the per-unit schedule queues of a wide compute core and its execution pipes. It keeps one dispatch slot for each execution unit. In every cycle it takes the candidate each queue offers, checks whether the resources that candidate's class needs are ready, and fills the slots. It then settles contention for the local-memory pipes and confirms that destination register writes can be booked. Every candidate that loses one of these steps goes back to its queue through a reinsert pulse.

A flat memory access uses a global-memory pipe and also the local-memory pipe that belongs to the same wave. A flat access that sits in a global-memory slot takes over the paired local-memory slot and marks it as skipped. If the flat access then fails its register-write check, both slots are released together. In the following cycle the registered slot states drive an execution-unit reservation vector. A reservation that lands twice on the same unit sets a sticky error flag.

Units are numbered with the ALU slots first (`N_ALU`), then the global-memory slots (`N_GM`), then the local-memory slots (`N_LM`). The slot state machine has three states: `SLOT_EMPTY` (code 0), `SLOT_EXREADY` (code 1) and `SLOT_SKIP` (code 2). It has four named transitions:
- **RELEASE**: every slot starts each cycle in EMPTY.
- **FILL**: EMPTY to EXREADY.
- **PREEMPT**: EXREADY or EMPTY to SKIP, on a local-memory slot.
- **ROLLBACK**: EXREADY or SKIP to EMPTY.

Top module: `dsa_slot_arbiter`

## Requirements
- R1: Slot j becomes EXREADY (code 1 in `slot_st_o[2j+1:2j]`) one clock after its candidate is valid and its class is ready; otherwise it reads EMPTY (code 0). Class codes are 0 no-op, 1 ALU/branch/barrier, 2 end-of-program, 3 global memory, 4 local memory and 5 flat. Codes 6 and 7 are never ready.
- R2: No-op and ALU classes need `rdy_flags_i[1]` (scalar ALU) when the scalar flag is set, and `rdy_flags_i[0]` (vector ALU) when it is clear. End-of-program needs bit 1 when scalar and nothing otherwise.
- R3: Vector global memory needs bits 2 (issue), 3 (bus), 4 (coalescer) and 5 (outstanding-request check). Scalar global memory needs bits 6 (issue), 7 (bus) and 8 (request FIFO).
- R4: Local memory needs bits 9 (issue), 10 (bus) and 11 (FIFO). Flat needs bits 2, 3, 4, 5, 10 and 11, and is only ever ready in a global-memory slot.
- R5: A global-memory slot that filled with a flat access moves local slot `N_ALU+N_GM+sel` to SKIP (code 2) and gives that slot the flat access's wave. If that local slot had filled, its entry is reinserted and `arb_stall_o` pulses for it.
- R6: A filled slot needs `srf_wr_ok_i` together with either `vrf_wr_ok_i` or the scalar flag. On failure, its entry is reinserted with its own wave and the slot reads EMPTY.
- R7: When a flat access fails R6, its paired local slot also reads EMPTY.
- R8: `rsv_units_o` is formed from the registered slot states. Each EXREADY slot sets its own bit, and a flat access also sets its paired local-memory bit.
- R9: A bit that is reserved twice in the same cycle sets `rsv_err_o` one clock later. The flag stays set until reset.
- R10: A filled memory access (codes 3, 4 and 5) presents its execution mask on `slot_mask_o`. A filled non-scalar global or flat access with `cand_tok_i` set pulses `tok_acq_o`.
- R11: During and just after reset, all slots are EMPTY and all pulses, the reservation vector and the error flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_vld_i | input | N_UNIT | Candidate present for each slot |
| cand_cls_i | input | 3*N_UNIT | Instruction class code for each slot |
| cand_scalar_i | input | N_UNIT | Scalar form of the instruction |
| cand_tok_i | input | N_UNIT | Instruction needs a coalescer token |
| cand_wave_i | input | WAVE_W*N_UNIT | Wave identifier |
| cand_lm_sel_i | input | LM_SEL_W*N_UNIT | Index of the wave's local-memory pipe |
| cand_mask_i | input | LANES*N_UNIT | Wave's current execution mask |
| vrf_wr_ok_i | input | N_UNIT | Vector register write can be booked |
| srf_wr_ok_i | input | N_UNIT | Scalar register write can be booked |
| rdy_flags_i | input | 12 | Resource readiness flags (bit map in R2 to R4) |
| slot_st_o | output | 2*N_UNIT | Registered slot states |
| slot_wave_o | output | WAVE_W*N_UNIT | Wave held by each slot |
| slot_mask_o | output | LANES*N_UNIT | Latched execution mask |
| reins_vld_o | output | N_UNIT | Reinsert pulse for each slot |
| reins_wave_o | output | WAVE_W*N_UNIT | Wave being returned to the queue |
| arb_stall_o | output | N_UNIT | Local-bus arbitration loss pulse |
| tok_acq_o | output | N_UNIT | Coalescer token acquired |
| rsv_units_o | output | N_UNIT | Execution units reserved this cycle |
| rsv_err_o | output | 1 | Sticky double-reservation error |

## Verification
The hardest situation to reach from the ports is a flat access that wins its local-pipe arbitration and then fails its register-write check. A random run needs a valid flat candidate in a global-memory slot, every flat flag set, a competing local-memory candidate, and one write-ok bit cleared, all in the same cycle. The double-reservation error needs two flat accesses in different global slots that name the same local pipe. Directed cycles set up both cases and then check the next-cycle error flag. Random traffic with mostly-ready flags then mixes these cases with ordinary fills.

// File: rtl/dsa_pkg.sv
package dsa_pkg;

    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'd0,
        SLOT_EXREADY = 2'd1,
        SLOT_SKIP    = 2'd2
    } slot_st_e;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_ALU    = 3'd1,
        OP_ENDPGM = 3'd2,
        OP_GMEM   = 3'd3,
        OP_LMEM   = 3'd4,
        OP_FLAT   = 3'd5
    } op_cls_e;

    // first member is the most significant bit: valu is bit 0, lm_fifo bit 11
    typedef struct packed {
        logic lm_fifo;
        logic lm_bus;
        logic lm_issue;
        logic sm_fifo;
        logic sm_bus;
        logic sm_issue;
        logic outst_ok;
        logic coal_rdy;
        logic gm_bus;
        logic gm_issue;
        logic salu;
        logic valu;
    } rdy_flags_t;

    localparam int RDY_W = $bits(rdy_flags_t);

endpackage

// File: rtl/dsa_ready_check.sv
module dsa_ready_check
    import dsa_pkg::*;
#(
    parameter bit IS_GM = 1'b0
) (
    input  logic [2:0] cls_i,
    input  logic       scalar_i,
    input  rdy_flags_t flags_i,
    output logic       ok_o
);

    always_comb begin
        unique case (op_cls_e'(cls_i))
            OP_NOP, OP_ALU: ok_o = scalar_i ? flags_i.salu : flags_i.valu;
            OP_ENDPGM:      ok_o = scalar_i ? flags_i.salu : 1'b1;
            OP_GMEM:        ok_o = scalar_i
                                 ? (flags_i.sm_issue & flags_i.sm_bus & flags_i.sm_fifo)
                                 : (flags_i.gm_issue & flags_i.gm_bus &
                                    flags_i.coal_rdy & flags_i.outst_ok);
            OP_LMEM:        ok_o = flags_i.lm_issue & flags_i.lm_bus & flags_i.lm_fifo;
            OP_FLAT:        ok_o = IS_GM & flags_i.gm_issue & flags_i.gm_bus &
                                   flags_i.lm_bus & flags_i.coal_rdy &
                                   flags_i.outst_ok & flags_i.lm_fifo;
            default:        ok_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dsa_reserve.sv
module dsa_reserve
    import dsa_pkg::*;
#(
    parameter int N_UNIT   = 6,
    parameter int FIRST_LM = 4,
    parameter int LM_SEL_W = 1
) (
    input  logic [2*N_UNIT-1:0]        st_i,
    input  logic [N_UNIT-1:0]          flat_i,
    input  logic [N_UNIT*LM_SEL_W-1:0] sel_i,
    output logic [N_UNIT-1:0]          units_o,
    output logic                       clash_o
);

    always_comb begin
        int lm;
        lm      = 0;
        units_o = '0;
        clash_o = 1'b0;
        for (int j = 0; j < N_UNIT; j++) begin
            if (slot_st_e'(st_i[2*j +: 2]) == SLOT_EXREADY) begin
                if (units_o[j]) clash_o = 1'b1;
                units_o[j] = 1'b1;
                if (flat_i[j]) begin
                    lm = FIRST_LM + int'(sel_i[j*LM_SEL_W +: LM_SEL_W]);
                    if (lm < N_UNIT) begin
                        if (units_o[lm]) clash_o = 1'b1;
                        units_o[lm] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dsa_slot_arbiter.sv
module dsa_slot_arbiter
    import dsa_pkg::*;
#(
    parameter int N_ALU  = 2,
    parameter int N_GM   = 2,
    parameter int N_LM   = 2,
    parameter int WAVE_W = 4,
    parameter int LANES  = 4,
    localparam int N_UNIT   = N_ALU + N_GM + N_LM,
    localparam int FIRST_GM = N_ALU,
    localparam int FIRST_LM = N_ALU + N_GM,
    localparam int LM_SEL_W = (N_LM > 1) ? $clog2(N_LM) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_UNIT-1:0]          cand_vld_i,
    input  logic [3*N_UNIT-1:0]        cand_cls_i,
    input  logic [N_UNIT-1:0]          cand_scalar_i,
    input  logic [N_UNIT-1:0]          cand_tok_i,
    input  logic [WAVE_W*N_UNIT-1:0]   cand_wave_i,
    input  logic [LM_SEL_W*N_UNIT-1:0] cand_lm_sel_i,
    input  logic [LANES*N_UNIT-1:0]    cand_mask_i,
    input  logic [N_UNIT-1:0]          vrf_wr_ok_i,
    input  logic [N_UNIT-1:0]          srf_wr_ok_i,
    input  logic [RDY_W-1:0]           rdy_flags_i,
    output logic [2*N_UNIT-1:0]        slot_st_o,
    output logic [WAVE_W*N_UNIT-1:0]   slot_wave_o,
    output logic [LANES*N_UNIT-1:0]    slot_mask_o,
    output logic [N_UNIT-1:0]          reins_vld_o,
    output logic [WAVE_W*N_UNIT-1:0]   reins_wave_o,
    output logic [N_UNIT-1:0]          arb_stall_o,
    output logic [N_UNIT-1:0]          tok_acq_o,
    output logic [N_UNIT-1:0]          rsv_units_o,
    output logic                       rsv_err_o
);

    rdy_flags_t          flags;
    logic [N_UNIT-1:0]   cls_ok;
    slot_st_e            nxt_st   [N_UNIT];
    logic [WAVE_W-1:0]   nxt_wave [N_UNIT];
    logic [LANES-1:0]    nxt_mask [N_UNIT];
    logic [N_UNIT-1:0]   nxt_flat, nxt_reins, nxt_stall, nxt_tok;

    logic [2*N_UNIT-1:0]        st_q;
    logic [N_UNIT-1:0]          flat_q;
    logic [LM_SEL_W*N_UNIT-1:0] sel_q;
    logic                       clash;
    logic                       err_q;

    assign flags = rdy_flags_t'(rdy_flags_i);

    // per-slot class readiness; flat is only legal in a global-memory slot
    for (genvar j = 0; j < N_UNIT; j++) begin : g_rdy
        dsa_ready_check #(.IS_GM((j >= FIRST_GM) && (j < FIRST_LM))) u_rc (
            .cls_i    (cand_cls_i[3*j +: 3]),
            .scalar_i (cand_scalar_i[j]),
            .flags_i  (flags),
            .ok_o     (cls_ok[j])
        );
    end

    // RELEASE -> FILL -> PREEMPT -> ROLLBACK, evaluated in one cycle
    always_comb begin
        int lm;
        lm = 0;
        for (int j = 0; j < N_UNIT; j++) begin
            nxt_st[j]    = SLOT_EMPTY;
            nxt_wave[j]  = cand_wave_i[WAVE_W*j +: WAVE_W];
            nxt_mask[j]  = '0;
            nxt_flat[j]  = 1'b0;
            nxt_reins[j] = 1'b0;
            nxt_stall[j] = 1'b0;
            nxt_tok[j]   = 1'b0;
        end
        // FILL
        for (int j = 0; j < N_UNIT; j++) begin
            if (cand_vld_i[j] && cls_ok[j]) begin
                nxt_st[j]   = SLOT_EXREADY;
                nxt_flat[j] = (op_cls_e'(cand_cls_i[3*j +: 3]) == OP_FLAT);
                nxt_tok[j]  = cand_tok_i[j] && !cand_scalar_i[j] &&
                              (op_cls_e'(cand_cls_i[3*j +: 3]) inside {OP_GMEM, OP_FLAT});
                if (op_cls_e'(cand_cls_i[3*j +: 3]) inside {OP_GMEM, OP_LMEM, OP_FLAT})
                    nxt_mask[j] = cand_mask_i[LANES*j +: LANES];
            end
        end
        // PREEMPT of the paired local-memory slot
        for (int g = FIRST_GM; g < FIRST_LM; g++) begin
            if (nxt_st[g] == SLOT_EXREADY && nxt_flat[g]) begin
                lm = FIRST_LM + int'(cand_lm_sel_i[LM_SEL_W*g +: LM_SEL_W]);
                if (lm < N_UNIT) begin
                    if (nxt_st[lm] == SLOT_EXREADY) begin
                        nxt_reins[lm] = 1'b1;
                        nxt_stall[lm] = 1'b1;
                    end
                    nxt_st[lm]   = SLOT_SKIP;
                    nxt_wave[lm] = cand_wave_i[WAVE_W*g +: WAVE_W];
                    nxt_mask[lm] = '0;
                    nxt_flat[lm] = 1'b0;
                end
            end
        end
        // ROLLBACK on a failed destination-write booking
        for (int j = 0; j < N_UNIT; j++) begin
            if (nxt_st[j] == SLOT_EXREADY &&
                !(srf_wr_ok_i[j] && (cand_scalar_i[j] || vrf_wr_ok_i[j]))) begin
                nxt_reins[j] = 1'b1;
                nxt_st[j]    = SLOT_EMPTY;
                if (nxt_flat[j]) begin
                    lm = FIRST_LM + int'(cand_lm_sel_i[LM_SEL_W*j +: LM_SEL_W]);
                    if (lm < N_UNIT) nxt_st[lm] = SLOT_EMPTY;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            for (int j = 0; j < N_UNIT; j++) st_q[2*j +: 2] <= nxt_st[j];
        end
    end

    // output and side-information registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_wave_o  <= '0;
            slot_mask_o  <= '0;
            flat_q       <= '0;
            sel_q        <= '0;
            reins_vld_o  <= '0;
            reins_wave_o <= '0;
            arb_stall_o  <= '0;
            tok_acq_o    <= '0;
            err_q        <= 1'b0;
        end else begin
            for (int j = 0; j < N_UNIT; j++) begin
                slot_wave_o[WAVE_W*j +: WAVE_W] <= nxt_wave[j];
                slot_mask_o[LANES*j +: LANES]   <= nxt_mask[j];
            end
            flat_q       <= nxt_flat;
            sel_q        <= cand_lm_sel_i;
            reins_vld_o  <= nxt_reins;
            reins_wave_o <= cand_wave_i;
            arb_stall_o  <= nxt_stall;
            tok_acq_o    <= nxt_tok;
            err_q        <= err_q | clash;
        end
    end

    dsa_reserve #(
        .N_UNIT   (N_UNIT),
        .FIRST_LM (FIRST_LM),
        .LM_SEL_W (LM_SEL_W)
    ) u_rsv (
        .st_i    (st_q),
        .flat_i  (flat_q),
        .sel_i   (sel_q),
        .units_o (rsv_units_o),
        .clash_o (clash)
    );

    assign slot_st_o = st_q;
    assign rsv_err_o = err_q;

endmodule

// File: rtl/dsa_checker.sv
module dsa_checker
    import dsa_pkg::*;
#(
    parameter int N_UNIT   = 6,
    parameter int FIRST_GM = 2,
    parameter int FIRST_LM = 4,
    parameter int WAVE_W   = 4,
    parameter int LM_SEL_W = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2*N_UNIT-1:0]        st,
    input logic [WAVE_W*N_UNIT-1:0]   wave,
    input logic [N_UNIT-1:0]          flat,
    input logic [LM_SEL_W*N_UNIT-1:0] sel,
    input logic [N_UNIT-1:0]          vld,
    input logic [N_UNIT-1:0]          scalar,
    input logic [N_UNIT-1:0]          tok_req,
    input logic [N_UNIT-1:0]          reins,
    input logic [N_UNIT-1:0]          tok,
    input logic [N_UNIT-1:0]          units,
    input logic                       err
);

    logic [N_UNIT-1:0] owner_ok;

    always_comb begin
        owner_ok = '0;
        for (int l = FIRST_LM; l < N_UNIT; l++) begin
            for (int g = FIRST_GM; g < FIRST_LM; g++) begin
                if (slot_st_e'(st[2*g +: 2]) == SLOT_EXREADY && flat[g] &&
                    (FIRST_LM + int'(sel[LM_SEL_W*g +: LM_SEL_W])) == l &&
                    wave[WAVE_W*g +: WAVE_W] == wave[WAVE_W*l +: WAVE_W])
                    owner_ok[l] = 1'b1;
            end
        end
    end

    for (genvar j = 0; j < N_UNIT; j++) begin : g_slot
        AST_FILL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (st[2*j +: 2] == 2'd1) |-> $past(vld[j])); // R1
        AST_REINSERT_FREES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            reins[j] |-> (st[2*j +: 2] != 2'd1)); // R6
        AST_TOKEN_VECTOR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            tok[j] |-> $past(tok_req[j] && !scalar[j])); // R10
        AST_EXREADY_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
            (st[2*j +: 2] == 2'd1) |-> units[j]); // R8
        if (j >= FIRST_LM) begin : g_lm
            AST_SKIP_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
                (st[2*j +: 2] == 2'd2) |-> owner_ok[j]); // R5
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err) |-> err); // R9

endmodule

bind dsa_slot_arbiter dsa_checker #(
    .N_UNIT   (N_UNIT),
    .FIRST_GM (FIRST_GM),
    .FIRST_LM (FIRST_LM),
    .WAVE_W   (WAVE_W),
    .LM_SEL_W (LM_SEL_W)
) u_dsa_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st_q),
    .wave    (slot_wave_o),
    .flat    (flat_q),
    .sel     (sel_q),
    .vld     (cand_vld_i),
    .scalar  (cand_scalar_i),
    .tok_req (cand_tok_i),
    .reins   (reins_vld_o),
    .tok     (tok_acq_o),
    .units   (rsv_units_o),
    .err     (rsv_err_o)
);

// File: tb/dsa_slot_arbiter_tb_top.sv
`timescale 1ns/1ps
module dsa_slot_arbiter_tb_top;

    localparam int NU = 6, WW = 4, LN = 4, SW = 1, FG = 2, FL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic           b_vld [NU];
    logic [2:0]     b_cls [NU];
    logic           b_sc  [NU];
    logic           b_tok [NU];
    logic [WW-1:0]  b_wave[NU];
    logic [SW-1:0]  b_sel [NU];
    logic [LN-1:0]  b_mask[NU];
    logic           b_vok [NU];
    logic           b_sok [NU];
    logic [11:0]    b_flags;

    logic [NU-1:0]    p_vld, p_sc, p_tok, p_vok, p_sok;
    logic [3*NU-1:0]  p_cls;
    logic [WW*NU-1:0] p_wave;
    logic [SW*NU-1:0] p_sel;
    logic [LN*NU-1:0] p_mask;

    always_comb begin
        for (int j = 0; j < NU; j++) begin
            p_vld[j] = b_vld[j];  p_sc[j] = b_sc[j];  p_tok[j] = b_tok[j];
            p_vok[j] = b_vok[j];  p_sok[j] = b_sok[j];
            p_cls[3*j +: 3]   = b_cls[j];
            p_wave[WW*j +: WW] = b_wave[j];
            p_sel[SW*j +: SW]  = b_sel[j];
            p_mask[LN*j +: LN] = b_mask[j];
        end
    end

    logic [2*NU-1:0]  o_st;
    logic [WW*NU-1:0] o_wave, o_rwave;
    logic [LN*NU-1:0] o_mask;
    logic [NU-1:0]    o_reins, o_stall, o_tok, o_rsv;
    logic             o_err;

    dsa_slot_arbiter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cand_vld_i(p_vld), .cand_cls_i(p_cls), .cand_scalar_i(p_sc),
        .cand_tok_i(p_tok), .cand_wave_i(p_wave), .cand_lm_sel_i(p_sel),
        .cand_mask_i(p_mask), .vrf_wr_ok_i(p_vok), .srf_wr_ok_i(p_sok),
        .rdy_flags_i(b_flags),
        .slot_st_o(o_st), .slot_wave_o(o_wave), .slot_mask_o(o_mask),
        .reins_vld_o(o_reins), .reins_wave_o(o_rwave), .arb_stall_o(o_stall),
        .tok_acq_o(o_tok), .rsv_units_o(o_rsv), .rsv_err_o(o_err)
    );

    int n_cmp = 0, n_bad = 0;

    int            e_st  [NU];
    logic [WW-1:0] e_wave[NU];
    logic [LN-1:0] e_mask[NU];
    logic [SW-1:0] e_sel [NU];
    logic          e_flat[NU], e_reins[NU], e_stall[NU], e_tok[NU];
    logic [WW-1:0] e_rwave[NU];
    logic          e_err;

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic bit m_ready(int j);
        bit sc = b_sc[j];
        bit gm = (j >= FG) && (j < FL);
        case (b_cls[j])
            3'd0, 3'd1: return sc ? b_flags[1] : b_flags[0];
            3'd2:       return sc ? b_flags[1] : 1'b1;
            3'd3:       return sc ? (b_flags[6] & b_flags[7] & b_flags[8])
                                  : (b_flags[2] & b_flags[3] & b_flags[4] & b_flags[5]);
            3'd4:       return b_flags[9] & b_flags[10] & b_flags[11];
            3'd5:       return gm & b_flags[2] & b_flags[3] & b_flags[4] &
                               b_flags[5] & b_flags[10] & b_flags[11];
            default:    return 1'b0;
        endcase
    endfunction

    function automatic void model_step();
        int lm;
        for (int j = 0; j < NU; j++) begin
            e_st[j] = 0; e_wave[j] = b_wave[j]; e_mask[j] = '0; e_sel[j] = b_sel[j];
            e_flat[j] = 0; e_reins[j] = 0; e_stall[j] = 0; e_tok[j] = 0;
            e_rwave[j] = b_wave[j];
        end
        for (int j = 0; j < NU; j++) begin
            if (b_vld[j] && m_ready(j)) begin
                e_st[j]   = 1;
                e_flat[j] = (b_cls[j] == 3'd5);
                e_tok[j]  = b_tok[j] && !b_sc[j] && (b_cls[j] == 3'd3 || b_cls[j] == 3'd5);
                if (b_cls[j] inside {3'd3, 3'd4, 3'd5}) e_mask[j] = b_mask[j];
            end
        end
        for (int g = FG; g < FL; g++) begin
            if (e_st[g] == 1 && e_flat[g]) begin
                lm = FL + int'(b_sel[g]);
                if (e_st[lm] == 1) begin e_reins[lm] = 1; e_stall[lm] = 1; end
                e_st[lm] = 2; e_wave[lm] = b_wave[g]; e_mask[lm] = '0; e_flat[lm] = 0;
            end
        end
        for (int j = 0; j < NU; j++) begin
            if (e_st[j] == 1 && !(b_sok[j] && (b_sc[j] || b_vok[j]))) begin
                e_reins[j] = 1; e_st[j] = 0;
                if (e_flat[j]) e_st[FL + int'(b_sel[j])] = 0;
            end
        end
    endfunction

    task automatic check_all(string tag);
        logic [NU-1:0] u;
        bit clash;
        logic [2*NU-1:0]  xs;
        logic [WW*NU-1:0] aw, xw, arw, xrw;
        logic [LN*NU-1:0] am, xm;
        logic [NU-1:0]    xr, xst, xt;
        u = '0; clash = 0;
        for (int j = 0; j < NU; j++) begin
            xs[2*j +: 2] = 2'(e_st[j]);
            aw[WW*j +: WW] = (e_st[j] != 0) ? o_wave[WW*j +: WW] : '0;
            xw[WW*j +: WW] = (e_st[j] != 0) ? e_wave[j] : '0;
            am[LN*j +: LN] = (e_st[j] == 1) ? o_mask[LN*j +: LN] : '0;
            xm[LN*j +: LN] = (e_st[j] == 1) ? e_mask[j] : '0;
            arw[WW*j +: WW] = e_reins[j] ? o_rwave[WW*j +: WW] : '0;
            xrw[WW*j +: WW] = e_reins[j] ? e_rwave[j] : '0;
            xr[j] = e_reins[j]; xst[j] = e_stall[j]; xt[j] = e_tok[j];
            if (e_st[j] == 1) begin
                if (u[j]) clash = 1;
                u[j] = 1'b1;
                if (e_flat[j]) begin
                    if (u[FL + int'(e_sel[j])]) clash = 1;
                    u[FL + int'(e_sel[j])] = 1'b1;
                end
            end
        end
        chk({tag, " R1 R5 R7 slot state"}, 64'(o_st), 64'(xs));
        chk({tag, " R5 slot wave"}, 64'(aw), 64'(xw));
        chk({tag, " R10 mask"}, 64'(am), 64'(xm));
        chk({tag, " R6 reinsert"}, 64'(o_reins), 64'(xr));
        chk({tag, " R6 reinsert wave"}, 64'(arw), 64'(xrw));
        chk({tag, " R5 arb stall"}, 64'(o_stall), 64'(xst));
        chk({tag, " R10 token"}, 64'(o_tok), 64'(xt));
        chk({tag, " R8 reserve"}, 64'(o_rsv), 64'(u));
        chk({tag, " R9 error"}, 64'(o_err), 64'(e_err));
        e_err = e_err | clash;
    endtask

    task automatic step(string tag);
        model_step();
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic idle_inputs();
        for (int j = 0; j < NU; j++) begin
            b_vld[j] = 0; b_cls[j] = 0; b_sc[j] = 0; b_tok[j] = 0; b_wave[j] = '0;
            b_sel[j] = '0; b_mask[j] = '0; b_vok[j] = 1; b_sok[j] = 1;
        end
        b_flags = 12'hFFF;
    endtask

    task automatic put(int j, int cls, bit sc, int wave, int sel);
        b_vld[j] = 1; b_cls[j] = 3'(cls); b_sc[j] = sc; b_wave[j] = WW'(wave); b_sel[j] = SW'(sel);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        chk("R11 reset state", 64'(o_st), 64'd0);
        chk("R11 reset pulses", 64'({o_reins, o_stall, o_tok}), 64'd0);
        chk("R11 reset reserve", 64'({o_rsv, o_err}), 64'd0);
        for (int j = 0; j < NU; j++) begin
            e_st[j] = 0; e_flat[j] = 0; e_reins[j] = 0; e_stall[j] = 0; e_tok[j] = 0;
            e_sel[j] = '0; e_wave[j] = '0; e_mask[j] = '0; e_rwave[j] = '0;
        end
        e_err = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        do_reset();

        // R5: flat in global slot 2 takes local slot 4 from a ready local access
        idle_inputs(); put(2, 5, 0, 5, 0); put(4, 4, 0, 9, 0);
        step("D1");
        chk("R5 local slot skipped", 64'(o_st[9:8]), 64'd2);
        chk("R5 loser reinserted", 64'(o_reins[4]), 64'd1);

        // R7: same pairing, flat fails its vector write booking
        idle_inputs(); put(2, 5, 0, 5, 0); put(4, 4, 0, 9, 0); b_vok[2] = 0;
        step("D2");
        chk("R7 global slot released", 64'(o_st[5:4]), 64'd0);
        chk("R7 local slot released", 64'(o_st[9:8]), 64'd0);

        // R3: scalar global memory blocked by a full request FIFO, then free
        idle_inputs(); put(3, 3, 1, 2, 0); b_flags[8] = 0;
        step("D3");
        chk("R3 scalar gmem fifo full", 64'(o_st[7:6]), 64'd0);
        idle_inputs(); put(3, 3, 1, 2, 0); b_flags[0] = 0;
        step("D3b");
        chk("R3 scalar gmem ignores valu", 64'(o_st[7:6]), 64'd1);

        // R2: scalar ALU busy blocks scalar ALU op but not vector one
        idle_inputs(); put(0, 1, 1, 3, 0); put(1, 1, 0, 4, 0); b_flags[1] = 0;
        step("D4");
        chk("R2 scalar alu busy", 64'(o_st[3:0]), 64'h4);

        // R4: flat outside a global slot, local access without FIFO space
        idle_inputs(); put(0, 5, 0, 6, 0); put(5, 4, 0, 7, 1); b_flags[11] = 0;
        step("D5");
        chk("R4 flat in alu slot", 64'(o_st[1:0]), 64'd0);
        chk("R4 local fifo full", 64'(o_st[11:10]), 64'd0);

        // R10: token for vector gmem only, mask latched
        idle_inputs(); put(2, 3, 0, 1, 0); b_tok[2] = 1; b_mask[2] = 4'hA;
        put(3, 3, 1, 2, 0); b_tok[3] = 1;
        step("D6");
        chk("R10 vector token", 64'(o_tok), 64'h04);
        chk("R10 mask latch", 64'(o_mask[11:8]), 64'hA);

        // R9: two flats naming the same local pipe collide
        idle_inputs(); put(2, 5, 0, 1, 1); put(3, 5, 0, 2, 1);
        step("D7");
        chk("R8 double claim visible", 64'(o_rsv), 64'h2C);
        idle_inputs();
        step("D7b");
        chk("R9 error raised", 64'(o_err), 64'd1);
        step("D7c");
        chk("R9 error sticky", 64'(o_err), 64'd1);

        do_reset();

        for (int c = 0; c < 3000; c++) begin
            for (int j = 0; j < NU; j++) begin
                b_vld[j]  = ($urandom % 4) != 0;
                b_cls[j]  = 3'($urandom % 7);
                b_sc[j]   = ($urandom % 3) == 0;
                b_tok[j]  = $urandom % 2;
                b_wave[j] = WW'($urandom);
                b_sel[j]  = SW'($urandom);
                b_mask[j] = LN'($urandom);
                b_vok[j]  = ($urandom % 6) != 0;
                b_sok[j]  = ($urandom % 6) != 0;
            end
            for (int k = 0; k < 12; k++) b_flags[k] = ($urandom % 8) != 0;
            step("RND R2 R3 R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule